// File: doc/BRIEF.md
# Multi-Channel UART Interrupt Aggregator

This block combines the interrupt requests of a group of UART channels and three device-wide sources into one read-only status word. The low byte has one flag per channel. The upper bits hold a packed field of 3-bit cause codes, one per channel. Each channel supplies its own request flag and its highest-priority cause, and the aggregator mirrors them. Channel 0's code slot is shared: the device-wide sources (wake-up, timer/counter, multi-purpose I/O) appear there only while channel 0 itself has no request.

The wake-up event is made inside the block. The event is raised when the all-channels-asleep condition ends. It is held until software reads a byte lane set that includes the summary byte. The read strobe is a one-cycle pulse that comes with a lane mask. Write strobes reach the block but have no effect on it. The status word is registered, so it reflects the inputs of the previous clock edge.

Top module: `irqagg_status`

## Requirements
- R1: During and right after a synchronous reset, every bit of `stat_word` is 0.
- R2: Bit n of `stat_word[7:0]` equals `ch_req[n]` as sampled at the previous rising edge. Bit 0 is channel 0.
- R3: For channel n >= 1, `stat_word[3n+10:3n+8]` equals that channel's cause `ch_cause[3n+2:3n]` when its request was set at the previous edge, and 3'b000 otherwise.
- R4: When `ch_req[0]` was set at the previous edge, `stat_word[10:8]` equals `ch_cause[2:0]`, whatever the device-wide sources are doing.
- R5: When `ch_req[0]` was clear, `stat_word[10:8]` shows the highest pending device-wide source. The order is wake-up (3'b101), then timer (3'b110), then I/O (3'b111). The value is 3'b000 when none is pending.
- R6: The wake-up flag is set on the rising edge where `&ch_asleep` goes from 1 (at the edge before) to 0. The flag reaches `stat_word[10:8]` one edge later.
- R7: A read pulse with `rd_lanes[0]` set clears the wake-up flag. A read pulse without `rd_lanes[0]` leaves the flag pending.
- R8: When a wake-up set and a clearing read fall on the same edge, the flag ends up set.
- R9: `wr_stb` and `wr_data` have no effect on `stat_word`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| ch_req | input | NUM_CH | Per-channel pending request |
| ch_cause | input | NUM_CH*CODE_W | Per-channel highest cause code, channel n at [CODE_W*n +: CODE_W] |
| ch_asleep | input | NUM_CH | Per-channel sleep state |
| tmr_irq | input | 1 | Timer/counter interrupt level |
| io_irq | input | 1 | Multi-purpose I/O interrupt level |
| rd_stb | input | 1 | One-cycle read pulse of the status word |
| rd_lanes | input | LANES | Byte lanes of the read, bit 0 = summary byte |
| wr_stb | input | 1 | Write pulse (ignored) |
| wr_data | input | STAT_W | Write data (ignored) |
| stat_word | output | STAT_W | Registered status word |

## Verification
The bench uses the default parameters: eight channels and 3-bit codes, which give the full 32-bit word with channel 7's code in bits [31:29]. At this size, random per-channel patterns reach every code slot, including the topmost field. The all-asleep vector is forced to all ones often enough that wake-up events keep happening during random reads. That exposes channel 0 slot sharing, set/clear collisions and partial-lane reads to the same run.

// File: rtl/irqagg_pkg.sv
package irqagg_pkg;
  typedef enum logic [2:0] {
    GC_NONE = 3'b000,
    GC_WAKE = 3'b101,
    GC_TMR  = 3'b110,
    GC_IO   = 3'b111
  } gcode_e;
endpackage

// File: rtl/irqagg_sleep_wake.sv
module irqagg_sleep_wake #(
  parameter int NUM_CH = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [NUM_CH-1:0] asleep_i,
  input  logic              clr_i,
  output logic              wake_o
);
  logic all_now;
  logic all_q;
  logic set_w;

  assign all_now = &asleep_i;
  assign set_w   = all_q & ~all_now;

  always_ff @(posedge clk) begin
    if (rst) begin
      all_q  <= 1'b0;
      wake_o <= 1'b0;
    end else begin
      all_q  <= all_now;
      // set has priority over a same-cycle clear
      wake_o <= set_w | (wake_o & ~clr_i);
    end
  end
endmodule

// File: rtl/irqagg_global_pick.sv
module irqagg_global_pick
  import irqagg_pkg::*;
#(
  parameter int CODE_W = 3
) (
  input  logic              wake_i,
  input  logic              tmr_i,
  input  logic              io_i,
  output logic [CODE_W-1:0] code_o
);
  always_comb begin
    if (wake_i)     code_o = CODE_W'(GC_WAKE);
    else if (tmr_i) code_o = CODE_W'(GC_TMR);
    else if (io_i)  code_o = CODE_W'(GC_IO);
    else            code_o = CODE_W'(GC_NONE);
  end
endmodule

// File: rtl/irqagg_code_pack.sv
module irqagg_code_pack #(
  parameter int NUM_CH = 8,
  parameter int CODE_W = 3,
  localparam int FLD_W = NUM_CH * CODE_W
) (
  input  logic [NUM_CH-1:0] req_i,
  input  logic [FLD_W-1:0]  cause_i,
  input  logic [CODE_W-1:0] glob_i,
  output logic [FLD_W-1:0]  field_o
);
  for (genvar n = 0; n < NUM_CH; n++) begin : g_slot
    if (n == 0) begin : g_shared
      // channel 0 own causes outrank device-wide sources
      assign field_o[CODE_W*n +: CODE_W] =
        req_i[n] ? cause_i[CODE_W*n +: CODE_W] : glob_i;
    end else begin : g_plain
      assign field_o[CODE_W*n +: CODE_W] =
        req_i[n] ? cause_i[CODE_W*n +: CODE_W] : '0;
    end
  end
endmodule

// File: rtl/irqagg_status.sv
module irqagg_status #(
  parameter int NUM_CH = 8,
  parameter int CODE_W = 3,
  parameter int STAT_W = NUM_CH * (CODE_W + 1),
  parameter int LANES  = (STAT_W + 7) / 8
) (
  input  logic                     clk,
  input  logic                     rst,
  input  logic [NUM_CH-1:0]        ch_req,
  input  logic [NUM_CH*CODE_W-1:0] ch_cause,
  input  logic [NUM_CH-1:0]        ch_asleep,
  input  logic                     tmr_irq,
  input  logic                     io_irq,
  input  logic                     rd_stb,
  input  logic [LANES-1:0]         rd_lanes,
  input  logic                     wr_stb,
  input  logic [STAT_W-1:0]        wr_data,
  output logic [STAT_W-1:0]        stat_word
);
  localparam int FLD_W = NUM_CH * CODE_W;

  logic              wake_w;
  logic              clr_w;
  logic [CODE_W-1:0] glob_w;
  logic [FLD_W-1:0]  field_w;
  logic              wr_unused;

  assign clr_w     = rd_stb & rd_lanes[0];
  assign wr_unused = wr_stb ^ (^wr_data);

  irqagg_sleep_wake #(.NUM_CH(NUM_CH)) u_wake (
    .clk     (clk),
    .rst     (rst),
    .asleep_i(ch_asleep),
    .clr_i   (clr_w),
    .wake_o  (wake_w)
  );

  irqagg_global_pick #(.CODE_W(CODE_W)) u_glob (
    .wake_i(wake_w),
    .tmr_i (tmr_irq),
    .io_i  (io_irq),
    .code_o(glob_w)
  );

  irqagg_code_pack #(.NUM_CH(NUM_CH), .CODE_W(CODE_W)) u_pack (
    .req_i  (ch_req),
    .cause_i(ch_cause),
    .glob_i (glob_w),
    .field_o(field_w)
  );

  always_ff @(posedge clk) begin
    if (rst) stat_word <= '0;
    else     stat_word <= STAT_W'({field_w, ch_req});
  end
endmodule

// File: rtl/irqagg_status_chk.sv
module irqagg_status_chk #(
  parameter int NUM_CH = 8,
  parameter int CODE_W = 3,
  parameter int STAT_W = 32
) (
  input logic                     clk,
  input logic                     rst,
  input logic [NUM_CH-1:0]        ch_req,
  input logic [NUM_CH*CODE_W-1:0] ch_cause,
  input logic                     tmr_irq,
  input logic [STAT_W-1:0]        stat_word
);
  logic past_ok;
  always_ff @(posedge clk) begin
    if (rst) past_ok <= 1'b0;
    else     past_ok <= 1'b1;
  end

  // R1
  a_r1_reset_clear: assert property (@(posedge clk)
    rst |=> stat_word == '0);

  // R2
  a_r2_summary: assert property (@(posedge clk) disable iff (rst)
    past_ok |-> stat_word[NUM_CH-1:0] == $past(ch_req));

  // R3
  a_r3_ch1_code: assert property (@(posedge clk) disable iff (rst)
    past_ok |-> stat_word[NUM_CH+CODE_W +: CODE_W] ==
      ($past(ch_req[1]) ? $past(ch_cause[CODE_W +: CODE_W]) : '0));

  // R4
  a_r4_ch0_wins: assert property (@(posedge clk) disable iff (rst)
    past_ok && $past(ch_req[0]) |->
      stat_word[NUM_CH +: CODE_W] == $past(ch_cause[0 +: CODE_W]));

  // R5
  a_r5_global_seen: assert property (@(posedge clk) disable iff (rst)
    past_ok && !$past(ch_req[0]) && $past(tmr_irq) |->
      stat_word[NUM_CH +: CODE_W] != '0);
endmodule

bind irqagg_status irqagg_status_chk #(
  .NUM_CH(NUM_CH), .CODE_W(CODE_W), .STAT_W(STAT_W)
) u_chk (
  .clk      (clk),
  .rst      (rst),
  .ch_req   (ch_req),
  .ch_cause (ch_cause),
  .tmr_irq  (tmr_irq),
  .stat_word(stat_word)
);

// File: tb/tb_irqagg_status.sv
module tb_irqagg_status;
  localparam int NCH = 8;
  localparam int CW  = 3;
  localparam int SW  = 32;
  localparam int LN  = 4;

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic [NCH-1:0] ch_req = '0;
  logic [NCH*CW-1:0] ch_cause = '0;
  logic [NCH-1:0] ch_asleep = '0;
  logic tmr_irq = 1'b0, io_irq = 1'b0, rd_stb = 1'b0, wr_stb = 1'b0;
  logic [LN-1:0] rd_lanes = '0;
  logic [SW-1:0] wr_data = '0;
  logic [SW-1:0] stat_word;

  int n_run = 0;
  int n_fail = 0;

  always #10 clk = ~clk;

  irqagg_status dut (
    .clk(clk), .rst(rst), .ch_req(ch_req), .ch_cause(ch_cause),
    .ch_asleep(ch_asleep), .tmr_irq(tmr_irq), .io_irq(io_irq),
    .rd_stb(rd_stb), .rd_lanes(rd_lanes), .wr_stb(wr_stb),
    .wr_data(wr_data), .stat_word(stat_word)
  );

  function automatic logic [SW-1:0] exp_word(
    input logic [NCH-1:0] rq, input logic [NCH*CW-1:0] cs,
    input logic wk, input logic tm, input logic io);
    logic [SW-1:0] w;
    w = '0;
    w[NCH-1:0] = rq;
    for (int n = 0; n < NCH; n++) begin
      logic [CW-1:0] c;
      if (rq[n])       c = cs[CW*n +: CW];
      else if (n != 0) c = 3'b000;
      else if (wk)     c = 3'b101;
      else if (tm)     c = 3'b110;
      else if (io)     c = 3'b111;
      else             c = 3'b000;
      w[NCH+CW*n +: CW] = c;
    end
    return w;
  endfunction

  // bench-side model of the requirements
  logic [SW-1:0] m_exp = '0;
  logic m_wake = 1'b0, m_allq = 1'b0;
  always @(posedge clk) begin
    if (rst) begin
      m_exp <= '0; m_wake <= 1'b0; m_allq <= 1'b0;
    end else begin
      m_exp  <= exp_word(ch_req, ch_cause, m_wake, tmr_irq, io_irq);
      m_wake <= (m_allq & ~(&ch_asleep)) | (m_wake & ~(rd_stb & rd_lanes[0]));
      m_allq <= &ch_asleep;
    end
  end

  task automatic chk(input string req, input logic [SW-1:0] got, input logic [SW-1:0] exp);
    n_run++;
    if (got !== exp) begin
      n_fail++;
      $display("FAIL %s: got %h expected %h", req, got, exp);
    end
  endtask

  // one cycle: wait for the negedge, compare fields against the model
  task automatic cyc();
    @(negedge clk);
    chk("R2", {24'b0, stat_word[7:0]}, {24'b0, m_exp[7:0]});
    chk(ch_req_q0 ? "R4" : "R5", {29'b0, stat_word[10:8]}, {29'b0, m_exp[10:8]});
    chk("R3", {8'b0, stat_word[31:11], 3'b0}, {8'b0, m_exp[31:11], 3'b0});
  endtask

  logic ch_req_q0 = 1'b0;
  always @(posedge clk) ch_req_q0 <= ch_req[0];

  task automatic idle_inputs();
    ch_req = '0; ch_cause = '0; ch_asleep = '0; tmr_irq = 0; io_irq = 0;
    rd_stb = 0; rd_lanes = '0; wr_stb = 0; wr_data = '0;
  endtask

  initial begin
    #(20 * 200000);
    n_fail++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    logic [SW-1:0] hold;
    void'($urandom(32'h5eed_1234));
    // R1: reset with busy inputs
    ch_req = 8'hFF; ch_cause = 24'hFFFFFF; tmr_irq = 1;
    repeat (3) @(negedge clk);
    chk("R1", stat_word, '0);
    idle_inputs();
    rst = 0;
    @(negedge clk);
    chk("R1", stat_word, '0);

    // R4: channel 0 cause beats globals
    ch_req = 8'h01; ch_cause = 24'h000002; tmr_irq = 1; io_irq = 1;
    cyc();
    chk("R4", {29'b0, stat_word[10:8]}, 32'd2);
    // R5: timer over io when channel 0 idle
    ch_req = 8'h00;
    cyc();
    chk("R5", {29'b0, stat_word[10:8]}, 32'd6);
    tmr_irq = 0;
    cyc();
    chk("R5", {29'b0, stat_word[10:8]}, 32'd7);
    io_irq = 0;
    // R3: top slot of channel 7
    ch_req = 8'h80; ch_cause = {3'b011, 21'h1FFFFF};
    cyc();
    chk("R3", stat_word, 32'h6000_0080);

    // R6 + R8: all asleep, then wake with clearing read in the same cycle
    idle_inputs(); ch_asleep = 8'hFF;
    cyc();
    ch_asleep = 8'h7F; rd_stb = 1; rd_lanes = 4'b0001;
    cyc();
    rd_stb = 0; rd_lanes = '0;
    cyc();
    chk("R8", {29'b0, stat_word[10:8]}, 32'd5);
    // R7: read of other lanes keeps the flag
    rd_stb = 1; rd_lanes = 4'b1110;
    cyc();
    rd_stb = 0; rd_lanes = '0;
    cyc();
    chk("R7", {29'b0, stat_word[10:8]}, 32'd5);
    // R6: wake outranks timer
    tmr_irq = 1;
    cyc();
    chk("R6", {29'b0, stat_word[10:8]}, 32'd5);
    // R7: summary-byte read clears it
    rd_stb = 1; rd_lanes = 4'b0001;
    cyc();
    rd_stb = 0; rd_lanes = '0;
    cyc();
    chk("R7", {29'b0, stat_word[10:8]}, 32'd6);
    tmr_irq = 0;

    // R9: writes ignored
    ch_req = 8'h24; ch_cause = 24'h0A5A5A;
    cyc();
    hold = stat_word;
    wr_stb = 1; wr_data = 32'hFFFF_FFFF;
    cyc();
    wr_stb = 0; wr_data = '0;
    cyc();
    chk("R9", stat_word, hold);

    // random phase, checked against the model every cycle
    for (int i = 0; i < 3000; i++) begin
      ch_req    = 8'($urandom);
      ch_cause  = 24'($urandom);
      ch_asleep = ($urandom % 3 == 0) ? 8'hFF : 8'($urandom);
      tmr_irq   = 1'($urandom);
      io_irq    = 1'($urandom);
      rd_stb    = ($urandom % 4 == 0);
      rd_lanes  = 4'($urandom);
      wr_stb    = 1'($urandom);
      wr_data   = $urandom;
      if (i % 5 == 0) ch_req[0] = 1'b0;
      cyc();
    end

    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule